// File: doc/BRIEF.md
# Serial Command Front End for a 12-bit DAC

This block is the digital control side of a 12-bit digital-to-analog converter. A host talks to it over a three-wire serial link. The link has an active-low frame select, a serial clock and a serial data input. Each frame carries 16 bits, most significant bit first. The top four bits are a command and the lower twelve are a data word. The block keeps the 12-bit code that drives the converter, plus two sticky mode bits: chained versus stand-alone operation, and which clock edge is active.

A serial data output makes it possible to chain several devices on a shared clock and frame select. The same output returns the DAC code to the host after a readback command. All three link inputs are sampled in one faster system clock domain. Each input passes through a synchronizer, and frame and clock transitions are found by edge detection. The whole block is therefore synchronous to `clk` and uses a synchronous active-high reset.

Top module: `dac_serial_ctrl`

## Requirements
- R1: After reset the DAC code is 0x000, the serial output is 0, the shift register is all zeros, chained mode is on and the falling clock edge is the active edge.
- R2: A frame shifts in MSB first. Bits 15..12 are the command and bits 11..0 are the data. Command 0001 copies the data bits into the DAC code.
- R3: Command 1001 switches to stand-alone mode and command 1010 makes the rising edge active. Both settings stay in force until reset.
- R4: Command 1011 sets the DAC code to 0x000 and command 1100 sets it to 0x800.
- R5: Command 0000 and every code with no function (for example 0011 and 1111) leave the DAC code and the modes unchanged.
- R6: While frame select is high, clock and data activity changes neither the DAC code nor the shift register.
- R7: In stand-alone mode the command executes on the 16th active edge after frame select falls, without waiting for frame select to rise. Further active edges in that frame do not shift.
- R8: In stand-alone mode, if frame select rises before the 16th active edge, the shift register is cleared and the DAC code and modes keep their values.
- R9: In chained mode any number of active edges shift the register. The command held in its upper four bits executes only when frame select rises.
- R10: The serial output shows the register MSB from the start of a frame and changes only on inactive edges. In chained mode, bits 16..31 of a 32-edge frame come out as the first 16 bits shifted in.
- R11: An inactive edge that arrives after frame select falls but before the first active edge does not shift or count.
- R12: Command 0010 loads the shift register with four zero bits above the current DAC code. These bits appear on the serial output during the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| fs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| dac_code | output | 12 | Code that drives the converter |
| sdo | output | 1 | Serial data out for chaining and readback |

## Verification
The assertions assume that every level of the serial clock lasts several system clocks. They also assume that a frame-select transition never falls in the same synchronized cycle as a clock edge, so one sampled cycle never shows two events. The bench holds each clock level for six system clocks. It moves frame select only while the serial clock is steady, and it changes data two cycles before the edge that samples it. The assertions also take the command field as the only thing that can alter the DAC code. Every stimulus therefore reaches the code through complete frames, an aborted frame, or activity with frame select high.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    localparam int FRAME_W = 16;
    localparam int CMD_W   = 4;
    localparam int DATA_W  = FRAME_W - CMD_W;
    localparam int CNT_W   = $clog2(FRAME_W) + 1;

    localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

    typedef enum logic [CMD_W-1:0] {
        OP_IDLE = 4'h0,
        OP_LOAD = 4'h1,
        OP_READ = 4'h2,
        OP_SOLO = 4'h9,
        OP_RISE = 4'hA,
        OP_ZERO = 4'hB,
        OP_MID  = 4'hC
    } op_e;

    typedef struct packed {
        logic [CMD_W-1:0]  op;
        logic [DATA_W-1:0] data;
    } frame_t;

    typedef struct packed {
        logic solo;
        logic rise;
    } mode_t;

    typedef struct packed {
        logic fs_low;
        logic fs_fall;
        logic fs_rise;
        logic act;
        logic inact;
        logic din;
    } evt_t;

    function automatic frame_t readback_word(input logic [DATA_W-1:0] code);
        frame_t f;
        f.op   = '0;
        f.data = code;
        return f;
    endfunction

endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
    parameter int          W      = 1,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] INIT  = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= INIT;
                    else     stage_q[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= INIT;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/dsc_shifter.sv
module dsc_shifter
    import dsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  evt_t              ev,
    input  logic              solo,
    input  logic [DATA_W-1:0] dac_code,
    output logic              exec,
    output frame_t            exec_word,
    output logic              sdo
);

    logic [FRAME_W-1:0] sreg;
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] shifted;
    logic               full;
    logic               solo_fire;
    logic               chain_fire;
    logic               readback;

    always_comb begin
        shifted    = {sreg[FRAME_W-2:0], ev.din};
        full       = (cnt == CNT_W'(FRAME_W));
        solo_fire  = solo && ev.act && (cnt == CNT_W'(FRAME_W - 1));
        chain_fire = !solo && ev.fs_rise;
        exec       = solo_fire || chain_fire;
        exec_word  = solo_fire ? frame_t'(shifted) : frame_t'(sreg);
        readback   = exec && (exec_word.op == OP_READ);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
            cnt  <= '0;
            sdo  <= 1'b0;
        end else if (ev.fs_fall) begin
            cnt <= '0;
            sdo <= sreg[FRAME_W-1];
        end else if (ev.fs_rise) begin
            if (readback) begin
                sreg <= readback_word(dac_code);
            end else if (solo && !full) begin
                sreg <= '0;
            end
        end else if (ev.act && !(solo && full)) begin
            sreg <= readback ? readback_word(dac_code) : shifted;
            if (!full) cnt <= cnt + 1'b1;
        end else if (ev.inact && cnt != '0) begin
            sdo <= sreg[FRAME_W-1];
        end
    end

endmodule

// File: rtl/dsc_cmd_reg.sv
module dsc_cmd_reg
    import dsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              exec,
    input  frame_t            exec_word,
    output logic [DATA_W-1:0] dac_code,
    output mode_t             mode
);

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_code  <= '0;
            mode.solo <= 1'b0;
            mode.rise <= 1'b0;
        end else if (exec) begin
            case (exec_word.op)
                OP_LOAD: dac_code  <= exec_word.data;
                OP_ZERO: dac_code  <= '0;
                OP_MID:  dac_code  <= MID_CODE;
                OP_SOLO: mode.solo <= 1'b1;
                OP_RISE: mode.rise <= 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dac_serial_ctrl.sv
module dac_serial_ctrl
    import dsc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic [DATA_W-1:0] dac_code,
    output logic              sdo
);

    logic [2:0] pins_s;
    logic       fs_prev;
    logic       sclk_prev;
    logic       sclk_up;
    logic       sclk_down;
    evt_t       ev;
    mode_t      mode;
    logic       exec;
    frame_t     exec_word;

    dsc_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES),
        .INIT   (3'b110)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({fs_n, sclk, sdi}),
        .q   (pins_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_prev   <= 1'b1;
            sclk_prev <= 1'b1;
        end else begin
            fs_prev   <= pins_s[2];
            sclk_prev <= pins_s[1];
        end
    end

    always_comb begin
        sclk_up    = !sclk_prev && pins_s[1];
        sclk_down  = sclk_prev && !pins_s[1];
        ev.fs_low  = !pins_s[2];
        ev.fs_fall = fs_prev && !pins_s[2];
        ev.fs_rise = !fs_prev && pins_s[2];
        ev.act     = ev.fs_low && (mode.rise ? sclk_up : sclk_down);
        ev.inact   = ev.fs_low && (mode.rise ? sclk_down : sclk_up);
        ev.din     = pins_s[0];
    end

    dsc_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .solo      (mode.solo),
        .dac_code  (dac_code),
        .exec      (exec),
        .exec_word (exec_word),
        .sdo       (sdo)
    );

    dsc_cmd_reg u_cmd (
        .clk       (clk),
        .rst       (rst),
        .exec      (exec),
        .exec_word (exec_word),
        .dac_code  (dac_code),
        .mode      (mode)
    );

endmodule

// File: rtl/dsc_checker.sv
module dsc_checker
    import dsc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              fs_low,
    input logic              fs_rise,
    input logic              fs_fall,
    input logic              inact,
    input logic              solo,
    input logic              rise,
    input logic              exec,
    input logic [CMD_W-1:0]  exec_op,
    input logic [DATA_W-1:0] dac_code,
    input logic              sdo
);

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!fs_low && !fs_rise) |=> $stable(dac_code)); // R6

    AST_SOLO_STICKY: assert property (@(posedge clk) disable iff (rst)
        solo |=> solo); // R3

    AST_RISE_STICKY: assert property (@(posedge clk) disable iff (rst)
        rise |=> rise); // R3

    AST_DAC_CAUSE: assert property (@(posedge clk) disable iff (rst)
        !$stable(dac_code) |-> $past(exec)); // R2

    AST_MID_VALUE: assert property (@(posedge clk) disable iff (rst)
        (exec && exec_op == OP_MID) |=> (dac_code == MID_CODE)); // R4

    AST_ABORT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (solo && fs_rise) |=> $stable(dac_code)); // R8

    AST_CHAIN_WAIT: assert property (@(posedge clk) disable iff (rst)
        (!solo && fs_low) |=> $stable(dac_code)); // R9

    AST_SDO_CAUSE: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdo) |-> $past(inact || fs_fall)); // R10

endmodule

bind dac_serial_ctrl dsc_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .fs_low   (ev.fs_low),
    .fs_rise  (ev.fs_rise),
    .fs_fall  (ev.fs_fall),
    .inact    (ev.inact),
    .solo     (mode.solo),
    .rise     (mode.rise),
    .exec     (exec),
    .exec_op  (exec_word.op),
    .dac_code (dac_code),
    .sdo      (sdo)
);

// File: tb/dac_serial_ctrl_bench.sv
module dac_serial_ctrl_bench;

    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fs_n = 1'b1;
    logic        sclk = 1'b1;
    logic        sdi = 1'b0;
    logic [11:0] dac_code;
    logic        sdo;

    int   n_checks = 0;
    int   n_fail   = 0;
    logic act_rise = 1'b0;
    logic [31:0] cap;

    always #4 clk = ~clk;

    dac_serial_ctrl u_dac_serial_ctrl (
        .clk      (clk),
        .rst      (rst),
        .fs_n     (fs_n),
        .sclk     (sclk),
        .sdi      (sdi),
        .dac_code (dac_code),
        .sdo      (sdo)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic ok, input string tag, input logic [31:0] got,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic shift_bits(input logic [31:0] w, input int nbits, input logic lead_inact);
        logic idle_lvl;
        idle_lvl = !act_rise;
        sclk = lead_inact ? !idle_lvl : idle_lvl;
        wait_clk(HALF);
        fs_n = 1'b0;
        wait_clk(HALF);
        if (lead_inact) begin
            sclk = idle_lvl;
            wait_clk(HALF);
        end
        cap = '0;
        for (int i = 0; i < nbits; i++) begin
            sdi = w[nbits-1-i];
            cap = {cap[30:0], sdo};
            wait_clk(2);
            sclk = !idle_lvl;
            wait_clk(HALF);
            sclk = idle_lvl;
            wait_clk(HALF);
        end
    endtask

    task automatic end_frame();
        fs_n = 1'b1;
        wait_clk(12);
    endtask

    task automatic send(input logic [15:0] w);
        shift_bits({16'h0, w}, 16, 1'b0);
        end_frame();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        fs_n = 1'b1;
        act_rise = 1'b0;
        sclk = 1'b1;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);
    endtask

    task automatic t_reset_state();
        do_reset();
        check(dac_code == 12'h000, "R1 dac after reset", 32'(dac_code), 32'h0);
        check(sdo == 1'b0, "R1 sdo after reset", 32'(sdo), 32'h0);
    endtask

    task automatic t_idle_ignored();
        for (int i = 0; i < 20; i++) begin
            sdi = i[0];
            sclk = ~sclk;
            wait_clk(HALF);
        end
        sclk = 1'b1;
        wait_clk(HALF);
        check(dac_code == 12'h000, "R6 dac with frame idle", 32'(dac_code), 32'h0);
    endtask

    task automatic t_chain_load();
        shift_bits(32'h1123, 16, 1'b0);
        check(cap[15:0] == 16'h0000, "R6 shift register untouched", 32'(cap[15:0]), 32'h0);
        check(dac_code == 12'h000, "R9 no execution before frame end", 32'(dac_code), 32'h0);
        end_frame();
        check(dac_code == 12'h123, "R2 load on frame end", 32'(dac_code), 32'h123);
    endtask

    task automatic t_chain_long();
        shift_bits(32'hF555_1456, 32, 1'b0);
        check(cap == 32'h1123_F555, "R10 chained output stream", cap, 32'h1123_F555);
        end_frame();
        check(dac_code == 12'h456, "R9 last 16 bits execute", 32'(dac_code), 32'h456);
    endtask

    task automatic t_clears();
        send(16'hC000);
        check(dac_code == 12'h800, "R4 midscale", 32'(dac_code), 32'h800);
        send(16'hB777);
        check(dac_code == 12'h000, "R4 zero", 32'(dac_code), 32'h0);
    endtask

    task automatic t_reserved();
        send(16'h1A5C);
        check(dac_code == 12'hA5C, "R2 load A5C", 32'(dac_code), 32'hA5C);
        send(16'h3FFF);
        send(16'h0123);
        send(16'hF000);
        check(dac_code == 12'hA5C, "R5 no-op and unused codes", 32'(dac_code), 32'hA5C);
    endtask

    task automatic t_readback();
        send(16'h2000);
        check(dac_code == 12'hA5C, "R12 readback keeps code", 32'(dac_code), 32'hA5C);
        shift_bits(32'h0000, 16, 1'b0);
        check(cap[15:0] == 16'h0A5C, "R12 readback stream", 32'(cap[15:0]), 32'h0A5C);
        end_frame();
    endtask

    task automatic t_solo();
        send(16'h9000);
        shift_bits(32'h0001_321F, 20, 1'b0);
        check(dac_code == 12'h321, "R7 executes on 16th edge", 32'(dac_code), 32'h321);
        check(dac_code == 12'h321, "R3 stand-alone mode active", 32'(dac_code), 32'h321);
        end_frame();
    endtask

    task automatic t_abort();
        shift_bits(32'h0000_07FF, 10, 1'b0);
        check(cap[9:0] == 10'h04C, "R7 extra edges did not shift", 32'(cap[9:0]), 32'h04C);
        end_frame();
        check(dac_code == 12'h321, "R8 abort keeps code", 32'(dac_code), 32'h321);
        shift_bits(32'h0000, 16, 1'b0);
        check(cap[15:0] == 16'h0000, "R8 abort cleared register", 32'(cap[15:0]), 32'h0);
        end_frame();
    endtask

    task automatic t_rise_mode();
        send(16'hA000);
        act_rise = 1'b1;
        sclk = 1'b0;
        wait_clk(HALF);
        shift_bits(32'h1777, 16, 1'b0);
        check(dac_code == 12'h777, "R3 rising edge active", 32'(dac_code), 32'h777);
        end_frame();
        shift_bits(32'h1888, 16, 1'b1);
        check(dac_code == 12'h888, "R11 leading inactive edge ignored", 32'(dac_code), 32'h888);
        end_frame();
    endtask

    task automatic t_reset_again();
        do_reset();
        check(dac_code == 12'h000, "R1 dac after second reset", 32'(dac_code), 32'h0);
        shift_bits(32'h1111, 16, 1'b0);
        check(dac_code == 12'h000, "R1 chained mode restored", 32'(dac_code), 32'h0);
        end_frame();
        check(dac_code == 12'h111, "R3 modes cleared by reset", 32'(dac_code), 32'h111);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_idle_ignored();
        t_chain_load();
        t_chain_long();
        t_clears();
        t_reserved();
        t_readback();
        t_solo();
        t_abort();
        t_rise_mode();
        t_reset_again();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule